// File: doc/BRIEF.md
# Quadrature-Corrected Resonant Feedback Divider

This block is the digital half of a phase-locked loop that keeps a resonant inverter on its resonant frequency. An external oscillator runs at twice the resonant frequency. The block turns it into two square waves at the resonant frequency. The first is a feedback reference that goes to an exclusive-OR phase detector. The second is the bridge drive reference, and it leads the feedback reference by a quarter of a resonant period. The phase detector compares the feedback reference with the digitised polarity of the tank current. An XOR detector settles with its two inputs in quadrature. Because the bridge reference sits a quarter period ahead of the feedback reference, the loop settles with bridge voltage and tank current in phase.

The block runs from a fast system clock. The oscillator and the current polarity both enter through the same two-flop synchroniser, so they see equal latency. The rising and falling edges of the synchronised oscillator act as the two opposite clock edges. One divide-by-two toggles on each rising edge and gives the feedback reference. A second divide-by-two toggles on each falling edge, and its inverse is the bridge reference. The quarter-period shift from the opposite edges and the half-period shift from the inversion together cancel the detector's quadrature offset.

A lock monitor measures the duty cycle of the detector output over a window of feedback periods. It raises a flag while that duty stays inside a band around one half. The band can be set while running. All pins are plain level signals. No data stream passes through the block, so there is no valid/ready handshake and nothing can apply back-pressure.

Top module: `qpll_quad_fb`

## Requirements
- R1: While `rst_n` is low, `fb_ref` is 0, `bridge_ref` is 1, `pd_out` is 0 and `locked` is 0, whatever the input levels.
- R2: Let `vco2x_in` be sampled as 1 at clock edge j and as 0 at edge j-1. Then `fb_ref` toggles at edge j+2. It changes at no other edge. The sample taken before the first edge after reset counts as being preceded by 0.
- R3: A 1-to-0 change of `vco2x_in` between samples j-1 and j toggles an internal stage at edge j+2, and `bridge_ref` is the inverse of that stage. As a result, `bridge_ref` changes half an oscillator period before `fb_ref` in steady running, and the two refer to the same resonant cycle.
- R4: `cur_pol_in` passes through a two-flop synchroniser. After clock edge n, `pd_out` equals `fb_ref` XOR the value of `cur_pol_in` sampled at edge n-1.
- R5: `pd_out` is 1 exactly when the feedback reference and the synchronised current polarity differ. A current in phase with `bridge_ref` gives exactly 50% duty. A current in phase with `fb_ref` gives 0%. A constant current polarity also gives 50%.
- R6: At every 16th clock edge where `fb_ref` goes from 0 to 1, the monitor takes every `pd_out` value seen since the previous evaluation (or since reset), including the cycle that ends at that edge. Let H be the number of those cycles with `pd_out` = 1 and T the number of cycles in total. `locked` becomes 1 when |2H - T| <= `lock_band`, otherwise 0. `locked` holds its value between evaluations.
- R7: Reset clears both divide stages and the edge history together. If `vco2x_in` is already high when reset is released, the first event seen is a rising edge, so the ordering of R2 and R3 holds from the first edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset for all stages |
| vco2x_in | input | 1 | Oscillator square wave at twice the resonant frequency, asynchronous |
| cur_pol_in | input | 1 | Tank current polarity from a comparator, asynchronous |
| lock_band | input | BAND_W (8) | Allowed value of abs(2H - T) over one window |
| fb_ref | output | 1 | Feedback reference to the phase detector, at the resonant frequency |
| bridge_ref | output | 1 | Bridge drive reference, a quarter period ahead of `fb_ref` |
| pd_out | output | 1 | XOR phase detector pulse stream |
| locked | output | 1 | Duty-cycle lock flag, updated once per window |

## Verification
The oscillator is run with half-periods of two to five clocks. For each half-period, the current polarity is a resonant-frequency square wave stepped through every phase offset one clock apart. This sweeps the detector duty from 0% through 50% to 100% and back. The sweep separates the quadrature lock point (bridge-aligned current) from the two saturated cases (current aligned with the feedback reference or with its inverse). A run with constant current polarity shows the XOR's 50% response to a signal without edges. Runs that start with the oscillator high at reset release show whether the first event is taken as a rising edge. The lock band is varied across runs, so the threshold comparison is tried on both sides of the limit.

// File: rtl/qpll_pkg.sv
package qpll_pkg;

  // Oscillator edge events seen in the system-clock domain.
  typedef struct packed {
    logic rise;
    logic fall;
  } vco_evt_t;

  localparam int SYNC_DEPTH_DEF = 2;

endpackage

// File: rtl/qpll_sync.sv
module qpll_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

  generate
    if (STAGES == 2) begin : g_lat_chk
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2)) |-> (q == $past(d, 2))) // R4
        else $error("synchroniser latency broken");
    end
  endgenerate

endmodule

// File: rtl/qpll_quad_div.sv
module qpll_quad_div
  import qpll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vco_s,
  output logic fb_q,
  output logic br_q,
  output logic win_tick
);

  logic     vco_d;
  vco_evt_t evt;

  always_comb begin
    evt.rise = vco_s & ~vco_d;
    evt.fall = ~vco_s & vco_d;
  end

  // Edge history and both divide-by-two stages share one reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vco_d <= 1'b0;
      fb_q  <= 1'b0;
      br_q  <= 1'b0;
    end else begin
      vco_d <= vco_s;
      if (evt.rise) fb_q <= ~fb_q;
      if (evt.fall) br_q <= ~br_q;
    end
  end

  // Start of a new feedback period.
  assign win_tick = evt.rise & ~fb_q;

  AST_RISE_SPLITS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rise |=> (fb_q != br_q)) // R3
    else $error("stages not split after rising edge");

  AST_FALL_JOINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fall |=> (fb_q == br_q)) // R3
    else $error("stages not joined after falling edge");

  AST_NO_TWIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_q != $past(fb_q)) |-> (br_q == $past(br_q))) // R7
    else $error("both stages toggled together");

endmodule

// File: rtl/qpll_lock_mon.sv
module qpll_lock_mon #(
  parameter int WIN_PER = 16,
  parameter int CNT_W   = 16,
  parameter int BAND_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd,
  input  logic              win_tick,
  input  logic [BAND_W-1:0] band,
  output logic              locked
);

  localparam int PER_W = (WIN_PER > 1) ? $clog2(WIN_PER) : 1;
  localparam int EXT_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] hi_q, tot_q, hi_nx, tot_nx;
  logic [PER_W-1:0] per_q;
  logic [EXT_W-1:0] twice_hi, tot_ext, mag;
  logic             sat, eval, in_band, locked_q;

  always_comb begin
    sat      = (tot_q == CNT_MAX);
    tot_nx   = sat ? tot_q : tot_q + CNT_W'(1);
    hi_nx    = sat ? hi_q  : hi_q + CNT_W'(pd);
    twice_hi = {1'b0, hi_nx, 1'b0};
    tot_ext  = {2'b00, tot_nx};
    mag      = (twice_hi >= tot_ext) ? (twice_hi - tot_ext) : (tot_ext - twice_hi);
    in_band  = (mag <= EXT_W'(band));
    eval     = win_tick && (per_q == PER_W'(WIN_PER - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      tot_q    <= '0;
      per_q    <= '0;
      locked_q <= 1'b0;
    end else if (eval) begin
      locked_q <= in_band;
      hi_q     <= '0;
      tot_q    <= '0;
      per_q    <= '0;
    end else begin
      hi_q  <= hi_nx;
      tot_q <= tot_nx;
      if (win_tick) per_q <= per_q + PER_W'(1);
    end
  end

  assign locked = locked_q;

  AST_HIGH_WITHIN_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q <= tot_q) // R6
    else $error("high count exceeds total");

  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable(locked_q)) // R6
    else $error("lock flag moved outside an evaluation");

endmodule

// File: rtl/qpll_quad_fb.sv
module qpll_quad_fb #(
  parameter int WIN_PER     = 16,
  parameter int CNT_W       = 16,
  parameter int BAND_W      = 8,
  parameter int SYNC_STAGES = qpll_pkg::SYNC_DEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vco2x_in,
  input  logic              cur_pol_in,
  input  logic [BAND_W-1:0] lock_band,
  output logic              fb_ref,
  output logic              bridge_ref,
  output logic              pd_out,
  output logic              locked
);

  logic [1:0] raw_in, sync_out;
  logic       fb_int, br_int, tick;

  assign raw_in = {cur_pol_in, vco2x_in};

  // One synchroniser for both asynchronous inputs: equal latency on each.
  qpll_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  qpll_quad_div u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .vco_s    (sync_out[0]),
    .fb_q     (fb_int),
    .br_q     (br_int),
    .win_tick (tick)
  );

  assign fb_ref     = fb_int;
  assign bridge_ref = ~br_int;
  assign pd_out     = fb_int ^ sync_out[1];

  qpll_lock_mon #(.WIN_PER(WIN_PER), .CNT_W(CNT_W), .BAND_W(BAND_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd       (pd_out),
    .win_tick (tick),
    .band     (lock_band),
    .locked   (locked)
  );

  AST_RESET_LEVELS: assert property (@(posedge clk)
    !rst_n |-> (!fb_ref && bridge_ref && !pd_out && !locked)) // R1
    else $error("outputs not at reset levels");

endmodule

// File: tb/tb_qpll_quad_fb.sv
module tb_qpll_quad_fb;

  localparam int MAXN = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vco2x_in = 1'b0;
  logic       cur_pol_in = 1'b0;
  logic [7:0] lock_band = '0;
  logic       fb_ref, bridge_ref, pd_out, locked;

  int n_cmp = 0;
  int n_bad = 0;
  bit vh [MAXN];
  bit ch [MAXN];

  always #4 clk = ~clk;

  qpll_quad_fb dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .vco2x_in   (vco2x_in),
    .cur_pol_in (cur_pol_in),
    .lock_band  (lock_band),
    .fb_ref     (fb_ref),
    .bridge_ref (bridge_ref),
    .pd_out     (pd_out),
    .locked     (locked)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input int cyc);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: cycle %0d got %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  function automatic bit gen_v(int n, int hh, int vo);
    return bit'(((n + vo) / hh) % 2);
  endfunction

  function automatic bit gen_c(int n, int hh, int dd, int cm);
    if (cm != 0) return 1'b0;
    return bit'(((n + dd) / (2 * hh)) % 2);
  endfunction

  task automatic run_cfg(input int hh, input int dd, input int vo, input int cm,
                         input int bnd, output bit last_lock);
    int  nedges = 160 * hh + 8;
    bit  fb_e = 0, br_e = 0, lock_e = 0, pd_e = 0, pd_prev = 0;
    bit  rv, fv, fb_new, tick;
    int  per = 0, hi = 0, tot = 0, hi_n, tot_n, df;
    string tag_div = (vo != 0) ? "R7" : "R2";
    string tag_br  = (vo != 0) ? "R7" : "R3";
    rst_n      = 1'b0;
    lock_band  = 8'(bnd);
    vh[0]      = gen_v(0, hh, vo);
    ch[0]      = gen_c(0, hh, dd, cm);
    vco2x_in   = vh[0];
    cur_pol_in = ch[0];
    repeat (2) @(posedge clk);
    #2;
    chk("R1", fb_ref, 1'b0, 0);
    chk("R1", bridge_ref, 1'b1, 0);
    chk("R1", pd_out, 1'b0, 0);
    chk("R1", locked, 1'b0, 0);
    rst_n = 1'b1;
    for (int n = 1; n < nedges; n++) begin
      @(posedge clk);
      #2;
      if (n >= 4) begin
        rv = vh[n-3] & ~vh[n-4];
        fv = ~vh[n-3] & vh[n-4];
      end else if (n == 3) begin
        rv = vh[0];
        fv = 1'b0;
      end else begin
        rv = 1'b0;
        fv = 1'b0;
      end
      fb_new = fb_e ^ rv;
      br_e   = br_e ^ fv;
      tick   = fb_new & ~fb_e;
      hi_n   = hi + int'(pd_prev);
      tot_n  = tot + 1;
      if (tick && per == 15) begin
        df = 2 * hi_n - tot_n;
        if (df < 0) df = -df;
        lock_e = (df <= bnd);
        hi = 0; tot = 0; per = 0;
      end else begin
        hi = hi_n; tot = tot_n;
        if (tick) per++;
      end
      fb_e = fb_new;
      pd_e = fb_e ^ ((n >= 2) ? ch[n-2] : 1'b0);
      chk(tag_div, fb_ref, fb_e, n);
      chk(tag_br, bridge_ref, ~br_e, n);
      chk("R4", pd_out, pd_e, n);
      chk("R6", locked, lock_e, n);
      pd_prev    = pd_e;
      vh[n]      = gen_v(n, hh, vo);
      ch[n]      = gen_c(n, hh, dd, cm);
      vco2x_in   = vh[n];
      cur_pol_in = ch[n];
    end
    last_lock = locked;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    bit lk;
    for (int hh = 2; hh <= 5; hh++) begin
      for (int dd = 0; dd < 4 * hh; dd++) begin
        run_cfg(hh, dd, (dd == 0) ? hh : 0, 0, dd % 8, lk);
        // R5: bridge-aligned current sits at the quadrature point, exact 50%
        if (dd == 2 * hh - 1) chk("R5", lk, 1'b1, 160 * hh);
        // R5: feedback-aligned current gives 0% duty, far outside any band used
        if (dd == hh - 1) chk("R5", lk, 1'b0, 160 * hh);
      end
    end
    // R5: constant polarity makes the detector follow the feedback reference
    run_cfg(4, 0, 0, 1, 0, lk);
    chk("R5", lk, 1'b1, 640);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule